// File: doc/BRIEF.md
# Infrared Receive Symbol Queue with Interrupt Logic

This block sits behind an infrared pulse encoder and gathers the run-length symbols it produces. Each symbol is one byte and is held in a small first-in first-out queue until software takes it by reading a data register. The same 32-bit register window holds the settings that steer the encoder: the enables, the operating mode, input inversion, and the noise and idle thresholds in samples. The block only stores these settings and drives them out as ports.

Three conditions are tracked in a status word: queue overflow, the end of a packet, and a fill level above a programmed threshold. Each condition is a sticky flag that is cleared by writing one to its bit. A per-flag enable masks the flags into a single interrupt line. The status word also reports the live number of queued symbols, so one status read tells software how many data reads to make.

The bus has no wait states. Read data is combinational on the cycle `bus_rd` is high, and a read of the data register pops the queue on the following clock edge. `bus_rd` is expected to be a single-cycle strobe for each access.

Top module: `ir_rx_ctrl`

## Requirements
- R1: After synchronous reset, every register reads as zero, the fill count is 0, and `irq` is low.
- R2: Register offsets are: control 0x00, receive configuration 0x10, data 0x20, interrupt enable 0x2C, status 0x30, and sample configuration 0x34. The control register holds global enable in bit 0, receive enable in bit 1, and mode in bits 5:4. The receive configuration register holds input invert in bit 2. The sample configuration register holds the noise threshold in bits 7:2 and the idle threshold in bits 15:8. Every one of these fields reads back as written and drives its matching output port; `rx_active` is the AND of global enable and receive enable.
- R3: A symbol is stored only when `sym_valid` is high and both enables are set; otherwise the fill count does not change.
- R4: The queue holds 16 bytes and returns them in arrival order. Each read of the data register pops one byte.
- R5: Status bits 13:8 report the current fill count.
- R6: When a symbol arrives while the queue is full, it is dropped, the stored contents are unchanged, and status bit 0 (overflow) is set.
- R7: A `sym_last` pulse while `rx_active` is high sets status bit 1 (packet end); a pulse while `rx_active` is low has no effect.
- R8: Status bit 4 (data available) is set one cycle after the fill count first exceeds the level held in interrupt-enable bits 11:8.
- R9: Writing status clears exactly the flags whose bit is written as one. Bits written as zero leave their flags unchanged. Writing 0xFF clears every flag, but data available sets again on the next cycle if the fill count still exceeds the level.
- R10: `irq` is high exactly when some flag is set and its enable bit is also set. Interrupt-enable bit 0 enables overflow, bit 1 enables packet end, and bit 4 enables data available.
- R11: A data read from an empty queue returns 0 and leaves the fill count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; pops on a data read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| sym_data | input | 8 | Symbol byte from the encoder |
| sym_valid | input | 1 | Symbol strobe |
| sym_last | input | 1 | Packet-end strobe from the encoder |
| irq | output | 1 | Interrupt request |
| rx_active | output | 1 | Both enables set |
| cfg_mode | output | 2 | Operating mode |
| cfg_invert | output | 1 | Input polarity invert |
| cfg_noise | output | 6 | Noise threshold in samples |
| cfg_idle | output | 8 | Idle threshold in samples |

## Verification
The threshold flag is swept across all 16 level settings against every fill count from 0 to 16. This separates a strict comparison from an inclusive one and catches errors in the level field position. The queue is filled with 16 distinct computed bytes and then overrun. This separates correct ordering, drop-on-full and preserved contents from pointer or count slips. The interrupt line is tried with all eight enable masks in each of four flag states, so a wrong bit mapping or a missing mask term shows up. Symbols offered with either enable cleared, packet-end pulses while idle, write-zero status writes and reads from an empty queue each show a change where none is allowed.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;

    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int SYM_W    = 8;
    localparam int Q_DEPTH  = 16;
    localparam int LEVEL_W  = 4;

    localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_RXCFG = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_DATA  = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_INTEN = 8'h2C;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 8'h30;
    localparam logic [ADDR_W-1:0] OFF_SAMP  = 8'h34;

    typedef struct packed {
        logic       glb_en;
        logic       rx_en;
        logic [1:0] mode;
        logic       invert;
        logic [5:0] noise;
        logic [7:0] idle;
        logic       en_ovf;
        logic       en_pend;
        logic       en_avail;
        logic [LEVEL_W-1:0] level;
    } cfg_t;

    typedef struct packed {
        logic ovf;
        logic pend;
        logic avail;
    } flags_t;

    function automatic logic [DATA_W-1:0] pack_flags(flags_t f);
        logic [DATA_W-1:0] w;
        w = '0;
        w[0] = f.ovf;
        w[1] = f.pend;
        w[4] = f.avail;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] pack_inten(cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[0] = c.en_ovf;
        w[1] = c.en_pend;
        w[4] = c.en_avail;
        w[11:8] = c.level;
        return w;
    endfunction

endpackage

// File: rtl/ir_rx_fifo.sv
module ir_rx_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    fill,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic             push_ok, pop_ok;

    assign full    = (fill == CW'(DEPTH));
    assign empty   = (fill == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rptr];

    function automatic logic [AW-1:0] step(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
        end else begin
            if (push_ok) wptr <= step(wptr);
            if (pop_ok)  rptr <= step(rptr);
            case ({push_ok, pop_ok})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
        fill <= CW'(DEPTH)); // R4
    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push) |=> (fill == '0)); // R11
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (fill == CW'(DEPTH))); // R6

endmodule

// File: rtl/ir_rx_cfg.sv
module ir_rx_cfg
    import ir_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output cfg_t              cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr) begin
            case (addr)
                OFF_CTRL: begin
                    cfg.glb_en <= wdata[0];
                    cfg.rx_en  <= wdata[1];
                    cfg.mode   <= wdata[5:4];
                end
                OFF_RXCFG: cfg.invert <= wdata[2];
                OFF_INTEN: begin
                    cfg.en_ovf   <= wdata[0];
                    cfg.en_pend  <= wdata[1];
                    cfg.en_avail <= wdata[4];
                    cfg.level    <= wdata[11:8];
                end
                OFF_SAMP: begin
                    cfg.noise <= wdata[7:2];
                    cfg.idle  <= wdata[15:8];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ir_rx_flags.sv
module ir_rx_flags
    import ir_rx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  flags_t set,
    input  flags_t clr,
    input  cfg_t   cfg,
    output flags_t flags,
    output logic   irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags.ovf   <= set.ovf   | (flags.ovf   & ~clr.ovf);
            flags.pend  <= set.pend  | (flags.pend  & ~clr.pend);
            flags.avail <= set.avail | (flags.avail & ~clr.avail);
        end
    end

    assign irq = (flags.ovf & cfg.en_ovf) | (flags.pend & cfg.en_pend)
               | (flags.avail & cfg.en_avail);

    AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
        set.ovf |=> flags.ovf); // R6
    AST_CLR_LOW: assert property (@(posedge clk) disable iff (rst)
        (clr.pend && !set.pend) |=> !flags.pend); // R9

endmodule

// File: rtl/ir_rx_ctrl.sv
module ir_rx_ctrl
    import ir_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [SYM_W-1:0]  sym_data,
    input  logic              sym_valid,
    input  logic              sym_last,
    output logic              irq,
    output logic              rx_active,
    output logic [1:0]        cfg_mode,
    output logic              cfg_invert,
    output logic [5:0]        cfg_noise,
    output logic [7:0]        cfg_idle
);
    localparam int CW = $clog2(Q_DEPTH + 1);

    cfg_t             cfg;
    flags_t           flags, fset, fclr;
    logic [SYM_W-1:0] head;
    logic [CW-1:0]    fill;
    logic             full, empty, pop, push;

    assign rx_active  = cfg.glb_en & cfg.rx_en;
    assign cfg_mode   = cfg.mode;
    assign cfg_invert = cfg.invert;
    assign cfg_noise  = cfg.noise;
    assign cfg_idle   = cfg.idle;

    assign push = sym_valid & rx_active;
    assign pop  = bus_rd && (bus_addr == OFF_DATA);

    ir_rx_cfg u_cfg (
        .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .cfg(cfg)
    );

    ir_rx_fifo #(.DEPTH(Q_DEPTH), .WIDTH(SYM_W)) u_fifo (
        .clk(clk), .rst(rst), .push(push), .push_data(sym_data),
        .pop(pop), .head(head), .fill(fill), .full(full), .empty(empty)
    );

    always_comb begin
        fset.ovf   = push & full;
        fset.pend  = sym_last & rx_active;
        fset.avail = (fill > CW'(cfg.level));
        fclr       = '0;
        if (bus_wr && bus_addr == OFF_STAT) begin
            fclr.ovf   = bus_wdata[0];
            fclr.pend  = bus_wdata[1];
            fclr.avail = bus_wdata[4];
        end
    end

    ir_rx_flags u_flags (
        .clk(clk), .rst(rst), .set(fset), .clr(fclr), .cfg(cfg),
        .flags(flags), .irq(irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                OFF_CTRL:  begin
                    bus_rdata[0]   = cfg.glb_en;
                    bus_rdata[1]   = cfg.rx_en;
                    bus_rdata[5:4] = cfg.mode;
                end
                OFF_RXCFG: bus_rdata[2] = cfg.invert;
                OFF_DATA:  bus_rdata[SYM_W-1:0] = empty ? '0 : head;
                OFF_INTEN: bus_rdata = pack_inten(cfg);
                OFF_STAT:  begin
                    bus_rdata = pack_flags(flags);
                    bus_rdata[13:8] = 6'(fill);
                end
                OFF_SAMP:  begin
                    bus_rdata[7:2]  = cfg.noise;
                    bus_rdata[15:8] = cfg.idle;
                end
                default: ;
            endcase
        end
    end

    AST_RX_GATED: assert property (@(posedge clk) disable iff (rst)
        (!rx_active && !pop) |=> $stable(fill)); // R3

endmodule

// File: tb/sim_ir_rx_ctrl.sv
module sim_ir_rx_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;

    logic        clk = 0, rst = 1;
    logic [7:0]  bus_addr = 0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic [7:0]  sym_data = 0;
    logic        sym_valid = 0, sym_last = 0;
    logic        irq, rx_active, cfg_invert;
    logic [1:0]  cfg_mode;
    logic [5:0]  cfg_noise;
    logic [7:0]  cfg_idle;

    int checks = 0, fails = 0;
    bit done = 0;

    ir_rx_ctrl u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=0x%08h exp=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
        @(negedge clk); bus_rd = 0;
    endtask

    task automatic sym(logic [7:0] v);
        @(negedge clk); sym_data = v; sym_valid = 1;
        @(negedge clk); sym_valid = 0;
    endtask

    task automatic drain();
        logic [31:0] d;
        for (int i = 0; i <= DEPTH; i++) rd(8'h20, d);
    endtask

    function automatic logic [7:0] pat(int i);
        return 8'((i * 37 + 5) & 8'hFF);
    endfunction

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk); cyc++;
            if (cyc > 150000) begin
                fails++; checks++;
                $display("FAIL watchdog act=%0d exp=done", cyc);
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] d;
        logic [7:0] offs [6] = '{8'h00, 8'h10, 8'h20, 8'h2C, 8'h30, 8'h34};
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        for (int i = 0; i < 6; i++) begin
            rd(offs[i], d); chk("R1 reg", d, 0);
        end
        chk("R1 irq", {31'b0, irq}, 0);

        // R2 config fields
        for (int v = 0; v < 4; v++) begin
            wr(8'h00, 32'((v << 4) | 3)); rd(8'h00, d);
            chk("R2 ctrl", d, 32'((v << 4) | 3));
            chk("R2 mode", {30'b0, cfg_mode}, 32'(v));
        end
        chk("R2 active", {31'b0, rx_active}, 1);
        wr(8'h00, 32'h31);
        chk("R2 active gen only", {31'b0, rx_active}, 0);
        wr(8'h00, 32'h32);
        chk("R2 active rx only", {31'b0, rx_active}, 0);
        wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, d);
        chk("R2 rxcfg", d, 32'h4); chk("R2 invert", {31'b0, cfg_invert}, 1);
        wr(8'h10, 0); chk("R2 invert0", {31'b0, cfg_invert}, 0);
        for (int n = 0; n < 64; n += 21) begin
            wr(8'h34, 32'(((n * 3 + 7) % 256) << 8 | (n << 2)));
            rd(8'h34, d);
            chk("R2 samp", d, 32'(((n * 3 + 7) % 256) << 8 | (n << 2)));
            chk("R2 noise", {26'b0, cfg_noise}, 32'(n));
            chk("R2 idle", {24'b0, cfg_idle}, 32'((n * 3 + 7) % 256));
        end

        // R3 gating: rx_en clear
        wr(8'h00, 32'h31); sym(8'hAA); rd(8'h30, d);
        chk("R3 gen only count", d[13:8], 0);
        wr(8'h00, 32'h32); sym(8'hAA); rd(8'h30, d);
        chk("R3 rx only count", d[13:8], 0);

        // R11 empty read
        rd(8'h20, d); chk("R11 empty data", d, 0);
        rd(8'h30, d); chk("R11 count", d[13:8], 0);

        // R4/R5 fill and order
        wr(8'h00, 32'h33);
        wr(8'h2C, 32'h0F00);
        for (int i = 0; i < DEPTH; i++) begin
            sym(pat(i)); rd(8'h30, d);
            chk("R5 count", d[13:8], 32'(i + 1));
        end
        chk("R6 no ovf yet", d[0], 0);
        // R6 overflow
        sym(8'h5A); rd(8'h30, d);
        chk("R6 ovf flag", d[0], 1); chk("R6 count held", d[13:8], 16);
        for (int i = 0; i < DEPTH; i++) begin
            rd(8'h20, d); chk("R4 order", d, {24'b0, pat(i)});
        end
        rd(8'h30, d); chk("R4 drained", d[13:8], 0);
        // R9 write zero leaves flags
        wr(8'h30, 0); rd(8'h30, d); chk("R9 write0", d[4:0], 5'h11);
        wr(8'h30, 32'hFF); rd(8'h30, d); chk("R9 clear all", d, 0);

        // R7 packet end
        wr(8'h00, 32'h31);
        @(negedge clk); sym_last = 1; @(negedge clk); sym_last = 0;
        rd(8'h30, d); chk("R7 idle pulse", d[1], 0);
        wr(8'h00, 32'h33);
        @(negedge clk); sym_last = 1; @(negedge clk); sym_last = 0;
        rd(8'h30, d); chk("R7 pend flag", d[1], 1);
        wr(8'h30, 32'h2); rd(8'h30, d); chk("R9 clear pend", d[1], 0);

        // R8 level sweep
        for (int lv = 0; lv < 16; lv++) begin
            drain();
            wr(8'h2C, 32'(lv << 8));
            wr(8'h30, 32'hFF);
            rd(8'h30, d); chk("R8 start", d[4], 0);
            for (int n = 1; n <= DEPTH; n++) begin
                sym(pat(n)); rd(8'h30, d);
                chk("R8 avail", d[4], (n > lv) ? 1 : 0);
            end
        end
        // R9 avail re-sets while still above level (level 15, fill 16)
        wr(8'h30, 32'h10); rd(8'h30, d); chk("R9 avail reasserts", d[4], 1);

        // R10 irq mask sweep across flag states
        sym(8'h01); sym_last = 0;
        @(negedge clk); sym_last = 1; @(negedge clk); sym_last = 0;
        for (int st = 0; st < 4; st++) begin
            logic [2:0] fl; // {avail, pend, ovf}
            if (st == 0) fl = 3'b111;
            else if (st == 1) begin wr(8'h30, 32'h1); fl = 3'b110; end
            else if (st == 2) begin wr(8'h30, 32'h2); fl = 3'b100; end
            else begin drain(); wr(8'h30, 32'h10); fl = 3'b000; end
            for (int m = 0; m < 8; m++) begin
                wr(8'h2C, 32'h0F00 | 32'(m[0]) | 32'(m[1]) << 1 | 32'(m[2]) << 4);
                chk("R10 irq", {31'b0, irq}, {31'b0, |(fl & 3'(m))});
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule